// File: doc/BRIEF.md
# Serial Shift Interface

The block is an 8-bit shift register with a 4-bit edge counter, built as a core for three-wire synchronous transfers or for a UART assisted by software. Software reaches it through a small register port. Through this port it loads and reads back the data register and the counter, sets the control fields, clears the overflow flag, and issues a software shift strobe.

A clock-select field picks the shift strobe from one of three sources: the software strobe bit, a one-cycle compare-match pulse from an external timer, or the serial clock pin. The serial clock pin passes through a two-flop synchronizer and an edge detector before use. Serial data enters at bit 0. Bit 7 drives the serial output through an output latch. With the pin clock selected, the latch is transparent only in the first half of each serial clock period, so data is sampled on one edge and the output changes on the other edge. The counter advances on every strobe. With the pin clock selected it advances on both edges of the pin clock. On a wrap from 15 to 0 it sets an overflow flag, which can raise an interrupt.

Register map: address 0 holds the data. Address 1 is the status register, with the flag in bit 7 and the counter in bits 3:0. Address 2 is the control register: bit 7 is the interrupt enable, bits 5:4 the wire mode, bits 3:2 the clock select, bit 1 the edge polarity and bit 0 the software strobe, which always reads 0. Address 3 reads 0.

Top module: `sshift_unit`

## Requirements
- R1: After reset every register reads 0, and sdo_o, sdo_oe_o and irq_o are 0.
- R2: Each shift strobe moves the data register left one place and loads sdi_i into bit 0.
- R3: Clock select (control bits 3:2) encodes the strobe source: 0 gives no strobe. 1 gives a strobe when control is written with bits 3:2 = 1 and bit 0 = 1, and that shift lands at the edge that ends the write. 2 takes the tmr_match_i pulse, and the shift lands at the next edge. 3 takes the serial clock pin.
- R4: A data-register write in the same cycle as a strobe stores the written value and no shift occurs. A status write in the same cycle as a count strobe loads bits 3:0 into the counter and the count step is lost.
- R5: With the pin clock selected, data shifts only on the edge picked by control bit 1 (0 rising, 1 falling). The shift lands at the third clock edge after the pin changes.
- R6: The counter advances by one per strobe. With the pin clock selected it advances on both rising and falling pin edges.
- R7: A counter wrap from 15 to 0 sets the flag (status bit 7). Writing status with bit 7 = 1 clears the flag. irq_o is high exactly when the flag and the interrupt enable (control bit 7) are both set.
- R8: With the pin clock selected, the serial output holds its value during the second half of the serial clock period, even across register writes, and follows bit 7 again in the first half. With an internal source selected, a new bit 7 shows on the output in the cycle after the write.
- R9: sdo_oe_o is high only when out_en_i is high and the wire mode (control bits 5:4) is nonzero. While sdo_oe_o is low, sdo_o is 0.
- R10: With wire mode 0, the strobes still shift the data register and advance the counter.
- R11: Status writes load the counter from bits 3:0, and the counter reads back in the same bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on the address |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdi_i | input | 1 | Serial data in |
| tmr_match_i | input | 1 | Timer compare-match pulse |
| out_en_i | input | 1 | Output enable for the serial data pin |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data out drive enable |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A software strobe and a data write take effect at the edge that ends the write. A timer pulse takes effect at the next edge. A pin change takes effect at the third edge, one edge for each of the two synchronizer flops and one for the register update. The bench drives every input 1 ns after a rising edge and reads the combinational read port before the next edge. For the pin clock it checks that nothing has changed after two edges and that the result is there after the third. The latch checks wait out the same three-edge delay before they compare the output against the phase of the serial clock.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef enum logic [1:0] {
    CS_OFF   = 2'd0,
    CS_SOFT  = 2'd1,
    CS_TIMER = 2'd2,
    CS_PIN   = 2'd3
  } clk_sel_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef struct packed {
    logic       ovf_ie;
    logic [1:0] wire_mode;
    clk_sel_e   clk_sel;
    logic       edge_pol;
  } ctrl_t;
endpackage

// File: rtl/sshift_sync.sv
module sshift_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = prev_q;
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sshift_datapath.sv
module sshift_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  input  logic              latch_open_i,
  output logic [DATA_W-1:0] data_o,
  output logic              msb_o
);
  logic [DATA_W-1:0] data_q;
  logic              latch_q;

  // write beats shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (wr_i)    data_q <= wdata_i;
    else if (shift_i) data_q <= {data_q[DATA_W-2:0], sdi_i};
  end

  assign msb_o = latch_open_i ? data_q[DATA_W-1] : latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b0;
    else         latch_q <= msb_o;
  end

  assign data_o = data_q;
endmodule

// File: rtl/sshift_counter.sv
module sshift_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flag_clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = tick_i & ~cnt_wr_i & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= cnt_wdata_i;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sshift_unit.sv
module sshift_unit
  import sshift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              tmr_match_i,
  input  logic              out_en_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CNT_W - 1;

  ctrl_t             ctrl_q;
  logic              wr_data, wr_stat, wr_ctrl;
  logic              soft_strobe, shift_tick, cnt_tick, latch_open;
  logic              pin_lvl, pin_rise, pin_fall, pin_shift;
  logic [DATA_W-1:0] data_val;
  logic [CNT_W-1:0]  cnt_val;
  logic              ovf_flag, msb_out;

  assign wr_data = reg_wr_i && (reg_addr_i == ADDR_DATA);
  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl)
      ctrl_q <= ctrl_t'({reg_wdata_i[7], reg_wdata_i[5:4], reg_wdata_i[3:2], reg_wdata_i[1]});
  end

  sshift_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sclk_i),
    .level_o(pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign soft_strobe = wr_ctrl && reg_wdata_i[0] && (reg_wdata_i[3:2] == CS_SOFT);
  assign pin_shift   = ctrl_q.edge_pol ? pin_fall : pin_rise;

  always_comb begin
    unique case (ctrl_q.clk_sel)
      CS_TIMER: shift_tick = tmr_match_i;
      CS_PIN:   shift_tick = pin_shift;
      default:  shift_tick = 1'b0;
    endcase
    shift_tick = shift_tick | soft_strobe;
    cnt_tick   = (ctrl_q.clk_sel == CS_PIN) ? (pin_rise | pin_fall) : shift_tick;
  end

  // first half of the serial period: synced level equals the idle level of the shift edge
  assign latch_open = (ctrl_q.clk_sel != CS_PIN) || (pin_lvl == ctrl_q.edge_pol);

  sshift_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_data),
    .wdata_i     (reg_wdata_i),
    .shift_i     (shift_tick),
    .sdi_i       (sdi_i),
    .latch_open_i(latch_open),
    .data_o      (data_val),
    .msb_o       (msb_out)
  );

  sshift_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_wr_i   (wr_stat),
    .cnt_wdata_i(reg_wdata_i[CNT_W-1:0]),
    .flag_clr_i (wr_stat && reg_wdata_i[DATA_W-1]),
    .tick_i     (cnt_tick),
    .cnt_o      (cnt_val),
    .flag_o     (ovf_flag)
  );

  assign sdo_oe_o = out_en_i && (ctrl_q.wire_mode != 2'd0);
  assign sdo_o    = sdo_oe_o && msb_out;
  assign irq_o    = ovf_flag && ctrl_q.ovf_ie;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = data_val;
      ADDR_STAT: reg_rdata_o = {ovf_flag, {PAD_W{1'b0}}, cnt_val};
      ADDR_CTRL: reg_rdata_o = DATA_W'({ctrl_q.ovf_ie, 1'b0, ctrl_q.wire_mode,
                                        ctrl_q.clk_sel, ctrl_q.edge_pol, 1'b0});
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sshift_unit_chk.sv
module sshift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              sdi_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] data_val,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              ovf_flag,
  input logic              shift_tick,
  input logic              cnt_tick,
  input logic              latch_open,
  input logic              msb_out
);
  logic wr_d, wr_s;
  assign wr_d = reg_wr_i && (reg_addr_i == 2'd0);
  assign wr_s = reg_wr_i && (reg_addr_i == 2'd1);

  assert_write_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d |=> data_val == $past(reg_wdata_i));

  assert_shift_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_tick && !wr_d) |=> data_val == {$past(data_val[DATA_W-2:0]), $past(sdi_i)});

  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick && !wr_s) |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

  assert_flag_on_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag) |-> $past(cnt_val) == {CNT_W{1'b1}});

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_flag);

  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_open && $past(!latch_open)) |-> $stable(msb_out));

  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
endmodule

bind sshift_unit sshift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .sdi_i      (sdi_i),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .irq_o      (irq_o),
  .data_val   (data_val),
  .cnt_val    (cnt_val),
  .ovf_flag   (ovf_flag),
  .shift_tick (shift_tick),
  .cnt_tick   (cnt_tick),
  .latch_open (latch_open),
  .msb_out    (msb_out)
);

// File: tb/sshift_unit_test.sv
`timescale 1ns/1ps
module sshift_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk = 1'b0, sdi = 1'b0, tmr = 1'b0, oen = 1'b0;
  logic       sdo, sdo_oe, irq;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sshift_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_i(sclk), .sdi_i(sdi),
    .tmr_match_i(tmr), .out_en_i(oen), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_o(irq)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rreg(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] e;
    tick(3);
    // R1: reset state
    chk_reg("R1 data", 2'd0, 8'h00);
    chk_reg("R1 status", 2'd1, 8'h00);
    chk_reg("R1 control", 2'd2, 8'h00);
    chk("R1 outputs", {5'd0, sdo, sdo_oe, irq}, 8'h00);
    rst_n = 1'b1;
    tick(2);
    chk_reg("R1 data after release", 2'd0, 8'h00);

    // R2 R3 R6 R7 R10: software strobe sweep over all data values, wire mode 0
    for (int v = 0; v < 256; v++) begin
      wreg(2'd0, 8'(v));
      sdi = v[3] ^ v[5];
      wreg(2'd2, 8'h05);
      e = 8'((v << 1) | (v[3] ^ v[5]));
      chk_reg("R2 R10 soft shift", 2'd0, e);
      e = {(v >= 15) ? 1'b1 : 1'b0, 3'b000, 4'((v + 1) % 16)};
      chk_reg("R6 R7 count and flag", 2'd1, e);
    end
    chk("R7 irq masked", {7'd0, irq}, 8'h00);
    chk_reg("R3 strobe bit reads 0", 2'd2, 8'h04);
    // R7 R11: clear flag, load counter
    wreg(2'd1, 8'h80);
    chk_reg("R7 flag clear", 2'd1, 8'h00);
    wreg(2'd1, 8'h0A);
    chk_reg("R11 counter load", 2'd1, 8'h0A);
    wreg(2'd1, 8'h00);

    // R3: timer source
    wreg(2'd2, 8'h08);
    sdi = 1'b1;
    wreg(2'd0, 8'h55);
    tmr = 1'b1; tick(1); tmr = 1'b0;
    chk_reg("R3 timer shift", 2'd0, 8'hAB);
    chk_reg("R3 timer count", 2'd1, 8'h01);
    // R4: same-cycle write and strobe
    tmr = 1'b1; wreg(2'd0, 8'h3C); tmr = 1'b0;
    chk_reg("R4 data write wins", 2'd0, 8'h3C);
    chk_reg("R4 counter still steps", 2'd1, 8'h02);
    tmr = 1'b1; wreg(2'd1, 8'h07); tmr = 1'b0;
    chk_reg("R4 status write wins", 2'd1, 8'h07);
    chk_reg("R4 shift on status write", 2'd0, 8'h79);
    // R3: source off
    wreg(2'd2, 8'h00);
    tmr = 1'b1; tick(1); tmr = 1'b0;
    chk_reg("R3 off no shift", 2'd0, 8'h79);
    chk_reg("R3 off no count", 2'd1, 8'h07);

    // R5 R6: pin clock, rising shift
    wreg(2'd2, 8'h0C);
    sdi = 1'b1; sclk = 1'b1;
    tick(2);
    chk_reg("R5 not yet at edge 2", 2'd0, 8'h79);
    tick(1);
    chk_reg("R5 shift at edge 3", 2'd0, 8'hF3);
    chk_reg("R6 rise counted", 2'd1, 8'h08);
    sclk = 1'b0; tick(4);
    chk_reg("R5 fall no shift", 2'd0, 8'hF3);
    chk_reg("R6 fall counted", 2'd1, 8'h09);
    // falling polarity
    wreg(2'd2, 8'h0E);
    sdi = 1'b0; sclk = 1'b1; tick(4);
    chk_reg("R5 pol1 rise no shift", 2'd0, 8'hF3);
    chk_reg("R6 pol1 rise counted", 2'd1, 8'h0A);
    sclk = 1'b0; tick(4);
    chk_reg("R5 pol1 fall shift", 2'd0, 8'hE6);
    chk_reg("R6 pol1 fall counted", 2'd1, 8'h0B);

    // R7: preloaded counter turns next pin edge into an interrupt
    wreg(2'd1, 8'h0F);
    wreg(2'd2, 8'h8E);
    sclk = 1'b1; tick(4);
    chk_reg("R7 wrap sets flag", 2'd1, 8'h80);
    chk("R7 irq raised", {7'd0, irq}, 8'h01);
    wreg(2'd1, 8'h80);
    chk("R7 irq cleared", {7'd0, irq}, 8'h00);

    // R8 R9: output latch, pin clock, rising shift
    wreg(2'd2, 8'h1C);
    oen = 1'b1;
    sclk = 1'b0; tick(4);
    wreg(2'd0, 8'h80);
    chk("R8 R9 first half transparent", {6'd0, sdo_oe, sdo}, 8'h03);
    sdi = 1'b0; sclk = 1'b1; tick(4);
    chk_reg("R8 shifted", 2'd0, 8'h00);
    chk("R8 held after shift", {7'd0, sdo}, 8'h01);
    wreg(2'd0, 8'h7F);
    chk("R8 held across write", {7'd0, sdo}, 8'h01);
    sclk = 1'b0; tick(4);
    chk("R8 follows in first half", {7'd0, sdo}, 8'h00);
    // internal source: immediate
    wreg(2'd2, 8'h14);
    wreg(2'd0, 8'h80);
    chk("R8 internal immediate", {7'd0, sdo}, 8'h01);
    oen = 1'b0; #1;
    chk("R9 out_en low", {6'd0, sdo_oe, sdo}, 8'h00);
    oen = 1'b1;
    wreg(2'd2, 8'h04);
    chk("R9 wire mode 0", {6'd0, sdo_oe, sdo}, 8'h00);

    finish_run();
  end
endmodule